// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block sits beside a small processor core and decides which clock domains run while the core sleeps. When the core issues a sleep command and the sleep-enable control bit is set, the controller stores the selected mode. It then drops the clock enables for the CPU, the I/O peripherals, the ADC and the asynchronous timer, and the enable of the main oscillator, according to that mode. Any wake source brings every domain back.

Six modes are supported. In the lightest mode only the CPU clock stops. In a conversion-quiet mode the ADC and the asynchronous timer keep running. The deepest mode stops everything, including the oscillator. Two modes keep the oscillator running so that wake-up is quick. When the oscillator was stopped, a programmable start-up delay holds the CPU clock off after wake until the oscillator has had time to settle. The block has no analog circuitry. It only produces enable levels for clock gates and oscillator control that sit outside it.

Top module: `sleep_gate_ctrl`

## Requirements
- R1: While `rstN` is low, every enable output is 1 and `sleeping` is 0. This holds from the moment reset asserts, also when reset arrives during sleep.
- R2: A sleep command given while `sleepEn` is 0 has no effect: all enables stay 1 and `sleeping` stays 0.
- R3: A sleep command with `sleepEn` at 1 and `modeSel` = 0 (idle) sets `sleeping` after the next clock edge. It clears only `cpuClkEn`.
- R4: Mode code 1 (ADC quiet) clears `cpuClkEn` and `ioClkEn`. It keeps `adcClkEn`, `tmrClkEn` and `oscEn` at 1.
- R5: Mode code 2 (power-down) clears every enable output, including `oscEn`.
- R6: Mode code 3 (power-save) clears every enable except `tmrClkEn`.
- R7: Mode code 6 (standby) clears every enable except `oscEn`.
- R8: Mode code 7 (extended standby) keeps only `tmrClkEn` and `oscEn` at 1.
- R9: The undefined mode codes 4 and 5 behave as code 0 (idle).
- R10: From modes 0, 1, 6 and 7, any bit of `wakeSrc` seen high at a clock edge restores all enables and clears `sleeping` after that same edge.
- R11: From modes 2 and 3, a wake with `startupCycles` = N > 0 first raises `oscEn`. For the next N sampled cycles `cpuClkEn`, `ioClkEn` and `adcClkEn` stay 0, `tmrClkEn` keeps its sleep value and `sleeping` stays 1. After that, all enables are 1 and `sleeping` is 0. With N = 0 the wake is immediate, as in R10.
- R12: A sleep command given while already asleep does not change the active mode or any enable.
- R13: A wake source asserted while awake has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepEn | input | 1 | Sleep-enable control bit; commands are ignored while 0 |
| sleepCmd | input | 1 | One-cycle sleep request from the core |
| modeSel | input | 3 | Sleep mode code, captured with the command |
| wakeSrc | input | NUM_WAKE | Interrupt and wake sources, any bit wakes |
| startupCycles | input | CNT_W | Oscillator start-up delay in cycles |
| cpuClkEn | output | 1 | CPU clock enable |
| ioClkEn | output | 1 | I/O peripheral clock enable |
| adcClkEn | output | 1 | ADC clock enable |
| tmrClkEn | output | 1 | Asynchronous timer clock enable |
| oscEn | output | 1 | Main oscillator enable |
| sleeping | output | 1 | High from sleep entry until the CPU clock is back |

## Verification
The bench builds the block with `CNT_W` = 4 and `NUM_WAKE` = 3. The largest start-up delay of 15 cycles can then be walked cycle by cycle, next to delays of 3 and 0. A wake from the highest source bit shows that sources other than bit 0 are also combined. With these sizes every mode code, including both undefined codes, is exercised with a full entry and wake sequence.

// File: rtl/sgc_pkg.sv
`timescale 1ns/1ps
package sgc_pkg;

  localparam int MODE_W = 3;

  // Field order: cpu, io, adc, tmr, osc
  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic tmr;
    logic osc;
  } domEn_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE  = 3'd0,
    MODE_ADCQ  = 3'd1,
    MODE_PDOWN = 3'd2,
    MODE_PSAVE = 3'd3,
    MODE_STBY  = 3'd6,
    MODE_XSTBY = 3'd7
  } sleepMode_t;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WARM  = 2'd2
  } pwrState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic enterSleep;
    logic loadDelay;
    logic countDown;
  } ctlStrobe_t;

  localparam domEn_t DOM_ALL_ON = 5'b11111;

  function automatic domEn_t modeDomains(sleepMode_t m);
    domEn_t d;
    case (m)
      MODE_IDLE:  d = 5'b01111;
      MODE_ADCQ:  d = 5'b00111;
      MODE_PDOWN: d = 5'b00000;
      MODE_PSAVE: d = 5'b00010;
      MODE_STBY:  d = 5'b00001;
      MODE_XSTBY: d = 5'b00011;
      default:    d = 5'b01111;
    endcase
    return d;
  endfunction

  // Modes that stop the oscillator need a start-up delay on wake
  function automatic logic needsWarmup(sleepMode_t m);
    return (m == MODE_PDOWN) || (m == MODE_PSAVE);
  endfunction

endpackage

// File: rtl/sgc_mode_map.sv
`timescale 1ns/1ps
module sgc_mode_map
  import sgc_pkg::*;
(
  input  logic [MODE_W-1:0] modeRaw,
  output sleepMode_t        modeClean
);

  always_comb begin
    case (modeRaw)
      3'd1:    modeClean = MODE_ADCQ;
      3'd2:    modeClean = MODE_PDOWN;
      3'd3:    modeClean = MODE_PSAVE;
      3'd6:    modeClean = MODE_STBY;
      3'd7:    modeClean = MODE_XSTBY;
      default: modeClean = MODE_IDLE;
    endcase
  end

endmodule

// File: rtl/sgc_ctrl.sv
`timescale 1ns/1ps
module sgc_ctrl
  import sgc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepCmd,
  input  logic       sleepEn,
  input  logic       wakeAny,
  input  logic       slowWake,
  input  logic       delayZero,
  input  logic       cntLast,
  output ctlStrobe_t strb,
  output pwrState_t  state
);

  pwrState_t stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_RUN: begin
        if (sleepCmd && sleepEn) begin
          strb.enterSleep = 1'b1;
          stateNext       = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (wakeAny) begin
          if (slowWake && !delayZero) begin
            strb.loadDelay = 1'b1;
            stateNext      = ST_WARM;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      ST_WARM: begin
        strb.countDown = 1'b1;
        if (cntLast) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sgc_datapath.sv
`timescale 1ns/1ps
module sgc_datapath
  import sgc_pkg::*;
#(
  parameter int CNT_W = 16
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  pwrState_t        state,
  input  sleepMode_t       modeClean,
  input  logic [CNT_W-1:0] startupCycles,
  output domEn_t           doms,
  output logic             sleeping,
  output logic             slowWake,
  output logic             delayZero,
  output logic             cntLast
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  sleepMode_t       modeQ;
  logic [CNT_W-1:0] cnt;
  domEn_t           sleepDoms;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_IDLE;
      cnt   <= '0;
    end else begin
      if (strb.enterSleep) modeQ <= modeClean;
      if (strb.loadDelay)      cnt <= startupCycles;
      else if (strb.countDown) cnt <= cnt - CNT_ONE;
    end
  end

  assign sleepDoms = modeDomains(modeQ);
  assign slowWake  = needsWarmup(modeQ);
  assign delayZero = (startupCycles == '0);
  assign cntLast   = (cnt == CNT_ONE);
  assign sleeping  = (state != ST_RUN);

  always_comb begin
    case (state)
      ST_SLEEP: doms = sleepDoms;
      ST_WARM: begin
        doms     = '0;
        doms.osc = 1'b1;
        doms.tmr = sleepDoms.tmr;
      end
      default: doms = DOM_ALL_ON;
    endcase
  end

endmodule

// File: rtl/sleep_gate_ctrl.sv
`timescale 1ns/1ps
module sleep_gate_ctrl
  import sgc_pkg::*;
#(
  parameter int NUM_WAKE = 8,
  parameter int CNT_W    = 16
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sleepEn,
  input  logic                sleepCmd,
  input  logic [MODE_W-1:0]   modeSel,
  input  logic [NUM_WAKE-1:0] wakeSrc,
  input  logic [CNT_W-1:0]    startupCycles,
  output logic                cpuClkEn,
  output logic                ioClkEn,
  output logic                adcClkEn,
  output logic                tmrClkEn,
  output logic                oscEn,
  output logic                sleeping
);

  ctlStrobe_t strb;
  pwrState_t  state;
  sleepMode_t modeClean;
  domEn_t     doms;
  logic       slowWake;
  logic       delayZero;
  logic       cntLast;

  sgc_mode_map u_map (
    .modeRaw   (modeSel),
    .modeClean (modeClean)
  );

  sgc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepCmd  (sleepCmd),
    .sleepEn   (sleepEn),
    .wakeAny   (|wakeSrc),
    .slowWake  (slowWake),
    .delayZero (delayZero),
    .cntLast   (cntLast),
    .strb      (strb),
    .state     (state)
  );

  sgc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .state         (state),
    .modeClean     (modeClean),
    .startupCycles (startupCycles),
    .doms          (doms),
    .sleeping      (sleeping),
    .slowWake      (slowWake),
    .delayZero     (delayZero),
    .cntLast       (cntLast)
  );

  assign cpuClkEn = doms.cpu;
  assign ioClkEn  = doms.io;
  assign adcClkEn = doms.adc;
  assign tmrClkEn = doms.tmr;
  assign oscEn    = doms.osc;

endmodule

// File: rtl/sgc_checker.sv
`timescale 1ns/1ps
module sgc_checker (
  input logic clk,
  input logic rstN,
  input logic sleepEn,
  input logic sleepCmd,
  input logic cpuClkEn,
  input logic ioClkEn,
  input logic adcClkEn,
  input logic tmrClkEn,
  input logic oscEn,
  input logic sleeping
);

  // R1
  reset_all_on_chk: assert property (@(posedge clk)
    !rstN |-> (cpuClkEn && ioClkEn && adcClkEn && tmrClkEn && oscEn && !sleeping));

  // R2
  no_entry_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && sleepCmd && !sleepEn) |=> !sleeping);

  // R3
  entry_stops_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && sleepCmd && sleepEn) |=> (sleeping && !cpuClkEn));

  // R10
  awake_all_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sleeping |-> (cpuClkEn && ioClkEn && adcClkEn && tmrClkEn && oscEn));

  // R5
  no_osc_no_io_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |-> (!cpuClkEn && !ioClkEn && !adcClkEn));

  // R12
  sleep_set_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && $past(sleeping) && $stable(oscEn)) |-> $stable({ioClkEn, adcClkEn, tmrClkEn}));

endmodule

bind sleep_gate_ctrl sgc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sleepEn  (sleepEn),
  .sleepCmd (sleepCmd),
  .cpuClkEn (cpuClkEn),
  .ioClkEn  (ioClkEn),
  .adcClkEn (adcClkEn),
  .tmrClkEn (tmrClkEn),
  .oscEn    (oscEn),
  .sleeping (sleeping)
);

// File: tb/sleep_gate_ctrl_tb.sv
`timescale 1ns/1ps
module sleep_gate_ctrl_tb;

  localparam int NUM_WAKE = 3;
  localparam int CNT_W    = 4;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                sleepEn = 1'b0;
  logic                sleepCmd = 1'b0;
  logic [2:0]          modeSel = '0;
  logic [NUM_WAKE-1:0] wakeSrc = '0;
  logic [CNT_W-1:0]    startupCycles = '0;
  logic cpuClkEn, ioClkEn, adcClkEn, tmrClkEn, oscEn, sleeping;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sleep_gate_ctrl #(.NUM_WAKE(NUM_WAKE), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .sleepCmd(sleepCmd),
    .modeSel(modeSel), .wakeSrc(wakeSrc), .startupCycles(startupCycles),
    .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn),
    .tmrClkEn(tmrClkEn), .oscEn(oscEn), .sleeping(sleeping)
  );

  // exp bit order: cpu, io, adc, tmr, osc
  task automatic chk(input string tag, input logic [4:0] exp, input logic expS);
    logic [4:0] got;
    got = {cpuClkEn, ioClkEn, adcClkEn, tmrClkEn, oscEn};
    checks++;
    if (got !== exp || sleeping !== expS) begin
      fails++;
      $display("FAIL %s: got en=%b sleeping=%b, expected en=%b sleeping=%b",
               tag, got, sleeping, exp, expS);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sleepCmd = 1'b0; sleepEn = 1'b0; wakeSrc = '0;
    repeat (2) @(negedge clk);
    chk("R1 during reset", 5'b11111, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", 5'b11111, 1'b0);
  endtask

  task automatic sleepReq(input logic [2:0] mode, input logic en);
    @(negedge clk);
    modeSel = mode; sleepEn = en; sleepCmd = 1'b1;
    @(negedge clk);
    sleepCmd = 1'b0;
  endtask

  task automatic wakeReq(input int bitIdx);
    @(negedge clk);
    wakeSrc[bitIdx] = 1'b1;
    @(negedge clk);
    wakeSrc = '0;
  endtask

  task automatic t_fastMode(input string tag, input logic [2:0] mode, input logic [4:0] exp);
    sleepReq(mode, 1'b1);
    chk({tag, " entry"}, exp, 1'b1);
    repeat (3) @(negedge clk);
    chk({tag, " holds"}, exp, 1'b1);
    wakeReq(0);
    chk("R10 fast wake", 5'b11111, 1'b0);
  endtask

  task automatic t_slowMode(input string tag, input logic [2:0] mode, input logic [4:0] exp,
                            input logic [CNT_W-1:0] delay, input int bitIdx);
    logic [4:0] warm;
    warm = {3'b000, exp[1], 1'b1};
    startupCycles = delay;
    sleepReq(mode, 1'b1);
    chk({tag, " entry"}, exp, 1'b1);
    wakeReq(bitIdx);
    if (delay == 0) begin
      chk("R11 zero delay wake", 5'b11111, 1'b0);
    end else begin
      chk("R11 warmup first", warm, 1'b1);
      for (int i = 1; i < int'(delay); i++) begin
        @(negedge clk);
        chk("R11 warmup hold", warm, 1'b1);
      end
      @(negedge clk);
      chk("R11 delay expired", 5'b11111, 1'b0);
    end
  endtask

  task automatic t_disabled();
    sleepReq(3'd2, 1'b0);
    chk("R2 command without enable", 5'b11111, 1'b0);
  endtask

  task automatic t_undefined();
    t_fastMode("R9 code 4", 3'd4, 5'b01111);
    t_fastMode("R9 code 5", 3'd5, 5'b01111);
  endtask

  task automatic t_reissue();
    startupCycles = 4'd2;
    sleepReq(3'd2, 1'b1);
    chk("R12 power-down entry", 5'b00000, 1'b1);
    sleepReq(3'd0, 1'b1);
    chk("R12 second command ignored", 5'b00000, 1'b1);
    wakeReq(1);
    chk("R12 wake uses held mode", 5'b00001, 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R12 wake done", 5'b11111, 1'b0);
  endtask

  task automatic t_spurious();
    wakeReq(2);
    chk("R13 wake while awake", 5'b11111, 1'b0);
    @(negedge clk);
    chk("R13 still awake", 5'b11111, 1'b0);
  endtask

  task automatic t_asyncReset();
    sleepReq(3'd2, 1'b1);
    chk("R5 entry before reset", 5'b00000, 1'b1);
    @(negedge clk);
    #1 rstN = 1'b0;
    #0.5;
    chk("R1 reset during sleep", 5'b11111, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 awake after reset", 5'b11111, 1'b0);
  endtask

  initial begin
    doReset();
    t_disabled();
    t_fastMode("R3 idle", 3'd0, 5'b01111);
    t_fastMode("R4 adc quiet", 3'd1, 5'b00111);
    t_slowMode("R5 power-down", 3'd2, 5'b00000, 4'd3, 0);
    t_slowMode("R6 power-save", 3'd3, 5'b00010, 4'd15, 2);
    t_slowMode("R5 power-down", 3'd2, 5'b00000, 4'd0, 1);
    t_slowMode("R6 power-save", 3'd3, 5'b00010, 4'd1, 0);
    t_fastMode("R7 standby", 3'd6, 5'b00001);
    t_fastMode("R8 ext standby", 3'd7, 5'b00011);
    t_undefined();
    t_reissue();
    t_spurious();
    t_asyncReset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule